// File: doc/BRIEF.md
# Bulk Endpoint Dual-Buffer Transmit and Receive Controller

This block holds the buffering and control for one bulk data endpoint of a full-speed USB device function. Two transmit buffers of one packet each (64 bytes by default) feed the IN direction. They can run as a single buffer chosen by a direction bit, or be linked into an alternating pair. A receive FIFO (128 bytes by default) collects OUT packets. The serial engine, line coding and CRC sit outside the block. The block sees tokens, packet bytes, host acknowledge and timeout, and answers each token with a handshake code.

Local logic loads transmit data and drains receive data through a byte port. A DMA engine can do the same through a second byte port, but only while its own enable is set. Control lives in a single 11-bit register. Some of its bits are cleared by hardware: the ready bits when a packet is acknowledged, the zero-length command when it is used, and the two FIFO reset strobes, which are never stored.

Top module: `bulk_pp_ep`

## Requirements
- R1: Link mode (cfg bit 5) turns cfg bits 0 and 1 into ready flags for buffer 0 and buffer 1. The transmitter starts on buffer 0 and moves to the other buffer after each acknowledged packet. Local writes also start on buffer 0 and move to the other buffer each time software sets the ready flag of the buffer being filled. An IN token on a buffer whose ready flag is clear gets NAK (resp_code 0).
- R2: A host acknowledge (usb_ack) after a DATA answer clears the ready flag of the sending buffer. In that same cycle, tx_done pulses for one cycle. The buffer is then emptied.
- R3: Writing 1 to cfg bit 3 makes the next IN token get a zero-length answer (resp_code 2). This takes priority over every other IN outcome. The bit then reads back 0.
- R4: With full-packet-only mode (cfg bit 4) set, an IN token on a buffer holding fewer than 64 bytes gets NAK.
- R5: With receive-off (cfg bit 2) set when an OUT token arrives, the packet ends in NAK, rx_done stays low and the receive contents and rx_level do not change.
- R6: cfg bit 9 empties both transmit buffers and cfg bit 10 empties the receive FIFO. Neither bit is stored: cfg_q carries only bits 8:0.
- R7: dma_wr loads the transmit side only while cfg bit 7 is set. dma_rd drains the receive side only while cfg bit 8 is set.
- R8: A write to the direction bit (cfg bit 6) has no effect while link mode is set.
- R9: An OUT packet larger than the free receive space gets NAK and is discarded. rx_level keeps its value from before the packet. A packet that fits gets ACK (resp_code 3), a one-cycle rx_done, and adds its length to rx_level.
- R10: usb_timeout rewinds the sending buffer so that tx_byte again shows the first byte of the packet.
- R11: Without link mode, the direction bit picks the buffer for both local writes and IN tokens. That buffer sends when its ready flag is set. The DATA answer is resp_code 1. tx_byte shows the current byte, and tx_last marks the last one.
- R12: resp_valid pulses with the answer in the cycle after tok_in, or in the cycle after rx_end for an OUT packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 11 | Control register write value |
| cfg_q | output | 9 | Stored control bits |
| loc_wr | input | 1 | Local write into the transmit buffer |
| loc_wdata | input | 8 | Local write byte |
| loc_rd | input | 1 | Local read from the receive FIFO |
| loc_rdata | output | 8 | Head byte of the receive FIFO |
| dma_wr | input | 1 | DMA write into the transmit buffer |
| dma_wdata | input | 8 | DMA write byte |
| dma_rd | input | 1 | DMA read from the receive FIFO |
| tok_in | input | 1 | IN token pulse |
| tok_out | input | 1 | OUT token pulse |
| usb_tx_rd | input | 1 | Advance to the next transmit byte |
| tx_byte | output | 8 | Current transmit byte |
| tx_last | output | 1 | Current transmit byte is the last one |
| usb_ack | input | 1 | Host acknowledged the IN packet |
| usb_timeout | input | 1 | Host acknowledge timed out |
| rx_wr | input | 1 | OUT packet byte valid |
| rx_byte | input | 8 | OUT packet byte |
| rx_end | input | 1 | OUT packet complete |
| resp_valid | output | 1 | Handshake answer valid |
| resp_code | output | 2 | 0 NAK, 1 DATA, 2 zero-length, 3 ACK |
| tx_done | output | 1 | Transmit-done pulse |
| rx_done | output | 1 | Receive-done pulse |
| rx_level | output | 8 | Committed bytes in the receive FIFO |

## Verification
Each result has a fixed timing:
- resp_valid and resp_code are registered, so they appear one edge after tok_in or rx_end.
- tx_done and the cleared ready flag appear together one edge after usb_ack.
- cfg_q, rx_level and tx_byte show the effect of a write, strobe or read one edge after it.

The bench drives every input on the falling edge and holds it for exactly one cycle. It samples on the next falling edge, which is the first point where the registered result is visible. Checks that something has no effect read cfg_q, rx_level or tx_byte in that same window, before the next stimulus.

// File: rtl/bulk_pp_ep.sv
module bulk_pp_ep #(
  parameter int PKT = 64,
  parameter int RXD = 128,
  parameter int DW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [10:0]      cfg_wdata,
  output logic [8:0]       cfg_q,
  input  logic             loc_wr,
  input  logic [DW-1:0]    loc_wdata,
  input  logic             loc_rd,
  output logic [DW-1:0]    loc_rdata,
  input  logic             dma_wr,
  input  logic [DW-1:0]    dma_wdata,
  input  logic             dma_rd,
  input  logic             tok_in,
  input  logic             tok_out,
  input  logic             usb_tx_rd,
  output logic [DW-1:0]    tx_byte,
  output logic             tx_last,
  input  logic             usb_ack,
  input  logic             usb_timeout,
  input  logic             rx_wr,
  input  logic [DW-1:0]    rx_byte,
  input  logic             rx_end,
  output logic             resp_valid,
  output logic [1:0]       resp_code,
  output logic             tx_done,
  output logic             rx_done,
  output logic [$clog2(RXD):0] rx_level
);
  localparam int TAW = $clog2(PKT);
  localparam int RAW = $clog2(RXD);
  localparam logic [TAW:0] PKTW = PKT[TAW:0];
  localparam logic [RAW:0] RXW  = RXD[RAW:0];
  localparam logic [1:0] R_NAK = 2'd0, R_DATA = 2'd1, R_ZLP = 2'd2, R_ACK = 2'd3;

  logic [DW-1:0] txm [2][PKT];
  logic [DW-1:0] rxm [RXD];
  logic [TAW:0]  twp [2];
  logic [TAW:0]  trp [2];
  logic [1:0]    rdy;
  logic          rx_off, zlp, full_only, link, dir, dma_tx_en, dma_rx_en;
  logic          pp, wb, infl;
  logic [RAW:0]  rwc, rws, rrp;
  logic          rx_act, rx_drop, rx_ovf;

  wire cur  = link ? pp : dir;
  wire fill = link ? wb : dir;
  wire          wr_tx = loc_wr | (dma_wr & dma_tx_en);
  wire [DW-1:0] wdat  = loc_wr ? loc_wdata : dma_wdata;
  wire          tx_we = wr_tx && (twp[fill] != PKTW);
  wire          rd_rx = (loc_rd | (dma_rd & dma_rx_en)) && (rrp != rwc);
  wire          rx_full = (rws - rrp) == RXW;
  wire          rx_in   = rx_wr && rx_act && !rx_drop && !rx_ovf;
  wire          rx_we   = rx_in && !rx_full;

  logic [1:0] in_code;
  always_comb begin
    if (zlp)                                   in_code = R_ZLP;
    else if (!rdy[cur])                        in_code = R_NAK;
    else if (full_only && twp[cur] != PKTW)    in_code = R_NAK;
    else                                       in_code = R_DATA;
  end

  assign cfg_q     = {dma_rx_en, dma_tx_en, dir, link, full_only, zlp, rx_off, rdy};
  assign tx_byte   = txm[cur][trp[cur][TAW-1:0]];
  assign tx_last   = (trp[cur] + {{TAW{1'b0}}, 1'b1}) == twp[cur];
  assign loc_rdata = rxm[rrp[RAW-1:0]];
  assign rx_level  = rwc - rrp;

  always_ff @(posedge clk) begin
    if (tx_we) txm[fill][twp[fill][TAW-1:0]] <= wdat;
    if (rx_we) rxm[rws[RAW-1:0]] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= '0; rx_off <= 1'b0; zlp <= 1'b0; full_only <= 1'b0; link <= 1'b0;
      dir <= 1'b0; dma_tx_en <= 1'b0; dma_rx_en <= 1'b0;
      pp <= 1'b0; wb <= 1'b0; infl <= 1'b0;
      twp[0] <= '0; twp[1] <= '0; trp[0] <= '0; trp[1] <= '0;
      rwc <= '0; rws <= '0; rrp <= '0;
      rx_act <= 1'b0; rx_drop <= 1'b0; rx_ovf <= 1'b0;
      resp_valid <= 1'b0; resp_code <= R_NAK; tx_done <= 1'b0; rx_done <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      tx_done    <= 1'b0;
      rx_done    <= 1'b0;
      if (cfg_wr) begin
        rdy       <= cfg_wdata[1:0];
        rx_off    <= cfg_wdata[2];
        zlp       <= cfg_wdata[3];
        full_only <= cfg_wdata[4];
        link      <= cfg_wdata[5];
        if (!link) dir <= cfg_wdata[6];
        dma_tx_en <= cfg_wdata[7];
        dma_rx_en <= cfg_wdata[8];
        if (cfg_wdata[5] && !link) begin
          pp <= 1'b0;
          wb <= 1'b0;
        end else if (link && cfg_wdata[wb] && !rdy[wb]) begin
          wb <= ~wb;
        end
      end
      if (tx_we) twp[fill] <= twp[fill] + 1'b1;
      if (tok_in) begin
        resp_valid <= 1'b1;
        resp_code  <= in_code;
        if (zlp) zlp <= 1'b0;
        if (in_code == R_DATA) infl <= 1'b1;
      end
      if (usb_tx_rd && trp[cur] != twp[cur]) trp[cur] <= trp[cur] + 1'b1;
      if (usb_timeout) trp[cur] <= '0;
      if (usb_ack && infl) begin
        infl     <= 1'b0;
        rdy[cur] <= 1'b0;
        tx_done  <= 1'b1;
        twp[cur] <= '0;
        trp[cur] <= '0;
        if (link) pp <= ~pp;
      end
      if (rd_rx) rrp <= rrp + 1'b1;
      if (tok_out) begin
        rx_act  <= 1'b1;
        rx_drop <= rx_off;
        rx_ovf  <= 1'b0;
        rws     <= rwc;
      end
      if (rx_we) rws <= rws + 1'b1;
      if (rx_in && rx_full) rx_ovf <= 1'b1;
      if (rx_end && rx_act) begin
        rx_act     <= 1'b0;
        resp_valid <= 1'b1;
        if (rx_drop || rx_ovf || (rx_in && rx_full)) begin
          resp_code <= R_NAK;
          rws       <= rwc;
        end else begin
          resp_code <= R_ACK;
          rwc       <= rx_we ? rws + 1'b1 : rws;
          rx_done   <= 1'b1;
        end
      end
      if (cfg_wr && cfg_wdata[9]) begin
        twp[0] <= '0; twp[1] <= '0; trp[0] <= '0; trp[1] <= '0;
        infl <= 1'b0;
      end
      if (cfg_wr && cfg_wdata[10]) begin
        rwc <= '0; rws <= '0; rrp <= '0;
      end
    end
  end

  p_idle_nak_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && !zlp && !rdy[cur]) |=> (resp_valid && resp_code == R_NAK));
  p_ack_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_ack && infl && !cfg_wr) |=> (tx_done && !rdy[$past(cur)]));
  p_zlp_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && zlp) |=> (resp_code == R_ZLP && !zlp));
  p_short_nak_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && !zlp && full_only && twp[cur] != PKTW && !tx_we) |=> (resp_code == R_NAK));
  p_rx_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && rx_act && rx_drop && !cfg_wr) |=> (resp_code == R_NAK && !rx_done && $stable(rwc)));
  p_dir_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && link) |=> $stable(dir));
  always_comb if (rst_n) p_no_overflow_r9: assert (rx_level <= RXW);
endmodule

// File: tb/bulk_pp_ep_tb.sv
module bulk_pp_ep_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0; logic [10:0] cfg_wdata = '0; logic [8:0] cfg_q;
  logic loc_wr = 0, loc_rd = 0, dma_wr = 0, dma_rd = 0;
  logic [7:0] loc_wdata = '0, dma_wdata = '0, loc_rdata, tx_byte, rx_byte = '0;
  logic tok_in = 0, tok_out = 0, usb_tx_rd = 0, usb_ack = 0, usb_timeout = 0;
  logic rx_wr = 0, rx_end = 0, tx_last, resp_valid, tx_done, rx_done;
  logic [1:0] resp_code;
  logic [7:0] rx_level;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bulk_pp_ep u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [10:0] v);
    cfg_wr = 1; cfg_wdata = v; @(negedge clk); cfg_wr = 0;
  endtask

  task automatic lwr(logic [7:0] b);
    loc_wr = 1; loc_wdata = b; @(negedge clk); loc_wr = 0;
  endtask

  task automatic in_tok(string req, logic [1:0] exp);
    tok_in = 1; @(negedge clk); tok_in = 0;
    chk(req, {resp_valid, resp_code}, {1'b1, exp});
  endtask

  task automatic ack(string req);
    usb_ack = 1; @(negedge clk); usb_ack = 0;
    chk(req, tx_done, 1);
  endtask

  task automatic pull();
    usb_tx_rd = 1; @(negedge clk); usb_tx_rd = 0;
  endtask

  task automatic out_pkt(int n, int base);
    tok_out = 1; @(negedge clk); tok_out = 0;
    for (int i = 0; i < n; i++) begin
      rx_wr = 1; rx_byte = 8'(base + i); @(negedge clk);
    end
    rx_wr = 0; rx_end = 1; @(negedge clk); rx_end = 0;
  endtask

  task automatic t_reset();
    chk("reset cfg_q", cfg_q, 0);
    chk("reset rx_level", rx_level, 0);
    chk("reset resp_valid", resp_valid, 0);
  endtask

  task automatic t_single();
    cfg(11'h040);
    lwr(8'h11); lwr(8'h22); lwr(8'h33);
    cfg(11'h042);
    in_tok("R11 R12 data answer", 2'd1);
    chk("R11 first byte", tx_byte, 8'h11);
    pull(); pull();
    chk("R11 third byte", {tx_last, tx_byte}, {1'b1, 8'h33});
    ack("R2 tx_done");
    chk("R2 ready cleared", cfg_q, 9'h040);
    in_tok("R1 not ready nak", 2'd0);
  endtask

  task automatic t_full_only();
    cfg(11'h010);
    for (int i = 0; i < 10; i++) lwr(8'(8'h80 + i));
    cfg(11'h011);
    in_tok("R4 short packet nak", 2'd0);
    for (int i = 10; i < 64; i++) lwr(8'(8'h80 + i));
    in_tok("R4 full packet data", 2'd1);
    pull(); pull();
    chk("R10 before timeout", tx_byte, 8'h82);
    usb_timeout = 1; @(negedge clk); usb_timeout = 0;
    chk("R10 rewound", tx_byte, 8'h80);
    ack("R2 tx_done full");
    cfg(11'h000);
  endtask

  task automatic t_zlp();
    cfg(11'h008);
    in_tok("R3 zero length", 2'd2);
    chk("R3 bit cleared", cfg_q, 0);
    in_tok("R3 one shot", 2'd0);
  endtask

  task automatic t_link();
    cfg(11'h020);
    lwr(8'hA0); lwr(8'hA1);
    cfg(11'h021);
    lwr(8'hB0); lwr(8'hB1);
    cfg(11'h023);
    in_tok("R1 buffer0 data", 2'd1);
    chk("R1 buffer0 byte", tx_byte, 8'hA0);
    ack("R2 tx_done buf0");
    chk("R2 rdy0 cleared", cfg_q[1:0], 2'b10);
    in_tok("R1 buffer1 data", 2'd1);
    chk("R1 buffer1 byte", tx_byte, 8'hB0);
    ack("R2 tx_done buf1");
    in_tok("R1 none ready nak", 2'd0);
    cfg(11'h060);
    chk("R8 dir locked", cfg_q, 9'h020);
    cfg(11'h000);
    cfg(11'h040);
    chk("R8 dir free unlinked", cfg_q, 9'h040);
    cfg(11'h000);
  endtask

  task automatic t_rx();
    out_pkt(5, 8'h40);
    chk("R9 ack", {resp_valid, resp_code, rx_done}, {1'b1, 2'd3, 1'b1});
    chk("R9 level 5", rx_level, 5);
    cfg(11'h004);
    out_pkt(3, 8'h10);
    chk("R5 nak", {resp_valid, resp_code, rx_done}, {1'b1, 2'd0, 1'b0});
    chk("R5 level kept", rx_level, 5);
    cfg(11'h000);
    out_pkt(64, 0);
    chk("R9 level 69", rx_level, 69);
    out_pkt(64, 0);
    chk("R9 overflow nak", {resp_code, rx_done}, {2'd0, 1'b0});
    chk("R9 level kept", rx_level, 69);
    chk("R9 head byte", loc_rdata, 8'h40);
    loc_rd = 1; @(negedge clk); loc_rd = 0;
    chk("R9 local read", {rx_level, loc_rdata}, {8'd68, 8'h41});
    dma_rd = 1; @(negedge clk); dma_rd = 0;
    chk("R7 dma read gated", rx_level, 68);
    cfg(11'h100);
    dma_rd = 1; @(negedge clk); dma_rd = 0;
    chk("R7 dma read enabled", rx_level, 67);
    cfg(11'h400);
    chk("R6 rx reset", {cfg_q, rx_level}, {9'h000, 8'd0});
  endtask

  task automatic t_dma_tx();
    dma_wr = 1; dma_wdata = 8'hEE; @(negedge clk); dma_wr = 0;
    cfg(11'h080);
    dma_wr = 1; dma_wdata = 8'h5A; @(negedge clk); dma_wr = 0;
    cfg(11'h081);
    in_tok("R7 dma data", 2'd1);
    chk("R7 dma byte only", {tx_last, tx_byte}, {1'b1, 8'h5A});
    ack("R2 tx_done dma");
    cfg(11'h000);
    lwr(8'h66);
    cfg(11'h200);
    lwr(8'h77);
    cfg(11'h001);
    in_tok("R6 after tx reset", 2'd1);
    chk("R6 tx emptied", {tx_last, tx_byte}, {1'b1, 8'h77});
    ack("R2 tx_done after reset");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_full_only();
    t_zlp();
    t_link();
    t_rx();
    t_dma_tx();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule